// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the arithmetic and logic stage of a small eight-bit processor datapath. Each cycle it receives two register operands, an immediate byte and a flat operation select. From these it produces a result byte and a destination write enable in the same cycle. It holds the six-bit status word in a register, and that register updates on the clock edge whenever the execute strobe `en_i` is high.

The stored flags feed back into the next operation. Carry enters the carry-using arithmetic, the shifts and the rotates. Zero chains across multi-byte subtracts and compares. Each operation rewrites only the flags it owns and leaves the others as they were.

The status word layout is: bit 0 carry C, bit 1 zero Z, bit 2 negative N, bit 3 overflow V, bit 4 sign S, bit 5 half-carry H. Operation codes are given in the requirements. In what follows, "result" means the eight-bit value on `res_o` in the same cycle, and "updated flags" means `flags_o` after the next rising edge with `en_i` high.

Top module: `alu8_core`

## Requirements
- R1: After reset, `flags_o` is 0.
- R2: Add (op 0) forms a+b, and add-with-carry (op 1) forms a+b+C. Both write the destination and update all six flags. C is the carry out of bit 7, H is the carry out of bit 3, V is the two's-complement overflow, Z means the result is zero and N is bit 7.
- R3: The subtract group forms a minus operand minus borrow, with C set on a borrow out of bit 7 and H set on a borrow out of bit 3. Subtract (op 2) uses b and immediate subtract (op 4) uses imm. Subtract-with-carry uses b (op 3) or imm (op 5). Two's complement (op 12) forms 0 minus a. All of them write the destination and update all six flags.
- R4: Subtract-with-carry (ops 3, 5) and compare-with-carry (op 16) clear Z when the result is nonzero and otherwise keep the previous Z.
- R5: Compare (op 15, b), compare-with-carry (op 16, b) and compare-immediate (op 17, imm) hold `wr_o` low and set the flags exactly as the matching subtract would.
- R6: AND (op 6 with b, op 7 with imm), OR (op 8 with b, op 9 with imm) and XOR (op 10) write the result and set Z, N and S. They clear V and keep C and H.
- R7: One's complement (op 11) yields 0xFF minus a, sets C, clears V, updates Z, N and S, and keeps H.
- R8: Increment (op 13) and decrement (op 14) update only Z, N, V and S. V is set when increment produces 0x80 or decrement produces 0x7F.
- R9: Shift left (op 18) fills bit 0 with 0, and rotate left (op 20) fills it with C. Both load bit 7 of a into C, load bit 3 of a into H and set V to N XOR C.
- R10: Shift right (op 19) fills bit 7 with 0, rotate right (op 21) fills it with C, and arithmetic shift right (op 22) keeps bit 7. All three load bit 0 of a into C, set V to N XOR C and keep H.
- R11: Nibble swap (op 23) exchanges the two four-bit halves of a, writes the destination and leaves every flag unchanged.
- R12: S always equals N XOR V. The flags never change on an edge where `en_i` is low.
- R13: Op codes 24 to 31 hold `wr_o` low and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Execute strobe; commits the new flags at the edge |
| op_i | input | 5 | Operation select |
| a_i | input | 8 | Destination/first operand |
| b_i | input | 8 | Second register operand |
| imm_i | input | 8 | Immediate operand |
| res_o | output | 8 | Result byte |
| wr_o | output | 1 | Destination write enable |
| flags_o | output | 6 | Stored status {H,S,V,N,Z,C} |

## Verification
The hardest behaviour to reach from the ports depends on flag history. Two cases matter most: the Z chaining of subtract-with-carry and compare-with-carry when the earlier Z was already clear, and the preserved H of logic and right-shift operations when H was previously set. Directed sequences handle the first: a compare-equal followed by a compare-with-carry-equal, then a compare that differs followed by one that is equal. Constrained random streams then run thousands of operations without resetting the flag register, so every operation meets both earlier C, Z and H values, and a random share of cycles leaves the strobe low.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_SUBI = 5'd4,  OP_SBCI = 5'd5,  OP_AND  = 5'd6,  OP_ANDI = 5'd7,
    OP_OR   = 5'd8,  OP_ORI  = 5'd9,  OP_XOR  = 5'd10, OP_COM  = 5'd11,
    OP_NEG  = 5'd12, OP_INC  = 5'd13, OP_DEC  = 5'd14, OP_CP   = 5'd15,
    OP_CPC  = 5'd16, OP_CPI  = 5'd17, OP_LSL  = 5'd18, OP_LSR  = 5'd19,
    OP_ROL  = 5'd20, OP_ROR  = 5'd21, OP_ASR  = 5'd22, OP_SWAP = 5'd23
  } alu_op_e;

  localparam int NFLAGS = 6;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] r_o,
  output logic         c_o,
  output logic         h_o,
  output logic         v_o
);
  localparam int HB = W / 2;

  logic [W-1:0] yy;
  logic         ci;
  logic [W:0]   full;
  logic [HB:0]  lo;

  // subtract as x + ~y + ~borrow; carries invert into borrows
  always_comb begin
    yy   = sub_i ? ~y_i : y_i;
    ci   = sub_i ? ~cin_i : cin_i;
    full = {1'b0, x_i} + {1'b0, yy} + {{W{1'b0}}, ci};
    lo   = {1'b0, x_i[HB-1:0]} + {1'b0, yy[HB-1:0]} + {{HB{1'b0}}, ci};
    r_o  = full[W-1:0];
    c_o  = sub_i ? ~full[W] : full[W];
    h_o  = sub_i ? ~lo[HB] : lo[HB];
    v_o  = (x_i[W-1] == yy[W-1]) && (full[W-1] != x_i[W-1]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] r_o
);
  always_comb begin
    unique case (op_i)
      OP_AND, OP_ANDI: r_o = a_i & b_i;
      OP_OR,  OP_ORI:  r_o = a_i | b_i;
      OP_XOR:          r_o = a_i ^ b_i;
      OP_COM:          r_o = ~a_i;
      default:         r_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  output logic [W-1:0] r_o,
  output logic         c_o
);
  localparam int HB = W / 2;

  always_comb begin
    r_o = a_i;
    c_o = cin_i;
    unique case (op_i)
      OP_LSL:  begin r_o = {a_i[W-2:0], 1'b0};      c_o = a_i[W-1]; end
      OP_ROL:  begin r_o = {a_i[W-2:0], cin_i};     c_o = a_i[W-1]; end
      OP_LSR:  begin r_o = {1'b0, a_i[W-1:1]};      c_o = a_i[0];   end
      OP_ROR:  begin r_o = {cin_i, a_i[W-1:1]};     c_o = a_i[0];   end
      OP_ASR:  begin r_o = {a_i[W-1], a_i[W-1:1]};  c_o = a_i[0];   end
      OP_SWAP: r_o = {a_i[HB-1:0], a_i[W-1:HB]};
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [4:0]        op_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [W-1:0]      imm_i,
  output logic [W-1:0]      res_o,
  output logic              wr_o,
  output logic [NFLAGS-1:0] flags_o
);
  localparam int HB = W / 2;

  alu_op_e           op;
  logic [W-1:0]      opnd;
  logic [NFLAGS-1:0] flags_q, nf;

  logic [W-1:0] as_x, as_y, as_r;
  logic         as_cin, as_sub, as_c, as_h, as_v;
  logic [W-1:0] lg_r, sh_r;
  logic         sh_c;

  assign op = alu_op_e'(op_i);

  always_comb begin
    unique case (op)
      OP_SUBI, OP_SBCI, OP_ANDI, OP_ORI, OP_CPI: opnd = imm_i;
      default:                                   opnd = b_i;
    endcase
  end

  // adder operand steering
  always_comb begin
    as_x   = a_i;
    as_y   = opnd;
    as_cin = 1'b0;
    as_sub = 1'b0;
    unique case (op)
      OP_ADC:                          as_cin = flags_q[FC];
      OP_SUB, OP_SUBI, OP_CP, OP_CPI:  as_sub = 1'b1;
      OP_SBC, OP_SBCI, OP_CPC: begin
        as_sub = 1'b1;
        as_cin = flags_q[FC];
      end
      OP_NEG: begin
        as_x   = '0;
        as_y   = a_i;
        as_sub = 1'b1;
      end
      OP_INC:  as_y = W'(1);
      OP_DEC: begin
        as_y   = W'(1);
        as_sub = 1'b1;
      end
      default: ;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .x_i(as_x), .y_i(as_y), .cin_i(as_cin), .sub_i(as_sub),
    .r_o(as_r), .c_o(as_c), .h_o(as_h), .v_o(as_v)
  );

  alu8_logic #(.W(W)) u_logic (
    .op_i(op), .a_i(a_i), .b_i(opnd), .r_o(lg_r)
  );

  alu8_shift #(.W(W)) u_shift (
    .op_i(op), .a_i(a_i), .cin_i(flags_q[FC]), .r_o(sh_r), .c_o(sh_c)
  );

  // result, write enable and next flags
  always_comb begin
    res_o = '0;
    wr_o  = 1'b0;
    nf    = flags_q;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SUBI, OP_NEG,
      OP_SBC, OP_SBCI, OP_CP, OP_CPI, OP_CPC: begin
        res_o  = as_r;
        wr_o   = !(op inside {OP_CP, OP_CPI, OP_CPC});
        nf[FC] = as_c;
        nf[FH] = as_h;
        nf[FV] = as_v;
        nf[FN] = as_r[W-1];
        nf[FZ] = (as_r == '0);
        if (op inside {OP_SBC, OP_SBCI, OP_CPC})
          nf[FZ] = (as_r == '0) && flags_q[FZ];
        nf[FS] = nf[FN] ^ nf[FV];
      end
      OP_AND, OP_ANDI, OP_OR, OP_ORI, OP_XOR, OP_COM: begin
        res_o  = lg_r;
        wr_o   = 1'b1;
        nf[FV] = 1'b0;
        nf[FN] = lg_r[W-1];
        nf[FZ] = (lg_r == '0);
        if (op == OP_COM) nf[FC] = 1'b1;
        nf[FS] = nf[FN];
      end
      OP_INC, OP_DEC: begin
        res_o  = as_r;
        wr_o   = 1'b1;
        nf[FV] = as_v;
        nf[FN] = as_r[W-1];
        nf[FZ] = (as_r == '0);
        nf[FS] = nf[FN] ^ nf[FV];
      end
      OP_LSL, OP_ROL, OP_LSR, OP_ROR, OP_ASR: begin
        res_o  = sh_r;
        wr_o   = 1'b1;
        nf[FC] = sh_c;
        nf[FN] = sh_r[W-1];
        nf[FZ] = (sh_r == '0);
        nf[FV] = sh_r[W-1] ^ sh_c;
        nf[FS] = sh_c;
        if (op inside {OP_LSL, OP_ROL}) nf[FH] = a_i[HB-1];
      end
      OP_SWAP: begin
        res_o = sh_r;
        wr_o  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flags_q <= '0;
    else if (en_i) flags_q <= nf;
  end

  assign flags_o = flags_q;

  // R12
  sign_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q[FS] == (flags_q[FN] ^ flags_q[FV]));

  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(flags_q));

  // R11
  swap_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 5'd23) |=> $stable(flags_q));

  // R13
  unused_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i > 5'd23) |=> $stable(flags_q));

  // R5
  cmp_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i inside {5'd15, 5'd16, 5'd17}) |-> !wr_o);

  // R6
  logic_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i inside {5'd6, 5'd7, 5'd8, 5'd9, 5'd10}) |=>
      (!flags_q[FV] && flags_q[FC] == $past(flags_q[FC]) && flags_q[FH] == $past(flags_q[FH])));

  // R7
  com_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 5'd11) |=> (flags_q[FC] && !flags_q[FV]));

  // R10
  rshift_h_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i inside {5'd19, 5'd21, 5'd22}) |=> $stable(flags_q[FH]));
endmodule

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] a = '0, b = '0, imm = '0;
  logic [7:0] res;
  logic       wr;
  logic [5:0] flags;

  int checks = 0;
  int errors = 0;
  logic [5:0] exp_fl = '0;

  always #2 clk = ~clk;

  alu8_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .op_i(op),
    .a_i(a), .b_i(b), .imm_i(imm),
    .res_o(res), .wr_o(wr), .flags_o(flags)
  );

  function automatic int sgn(int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  function automatic string req_of(int o);
    case (o)
      0, 1:             return "R2";
      2, 4, 12:         return "R3";
      3, 5:             return "R4";
      15, 16, 17:       return "R5";
      6, 7, 8, 9, 10:   return "R6";
      11:               return "R7";
      13, 14:           return "R8";
      18, 20:           return "R9";
      19, 21, 22:       return "R10";
      23:               return "R11";
      default:          return "R13";
    endcase
  endfunction

  // flags packed as {H,S,V,N,Z,C}
  task automatic model(input int o, input int ai, input int bi, input int ii,
                       input logic [5:0] fl, output int r, output bit w,
                       output logic [5:0] nf);
    int y, cin, d, sv;
    bit c, z, n, v, h, s;
    c = fl[0]; z = fl[1]; n = fl[2]; v = fl[3]; s = fl[4]; h = fl[5];
    y = (o inside {4, 5, 7, 9, 17}) ? ii : bi;
    r = 0; w = 0;
    case (o)
      0, 1: begin
        cin = (o == 1) ? int'(c) : 0;
        d = ai + y + cin; r = d & 255; w = 1;
        c = d > 255; h = ((ai & 15) + (y & 15) + cin) > 15;
        sv = sgn(ai) + sgn(y) + cin; v = (sv > 127) || (sv < -128);
        z = (r == 0); n = r[7]; s = n ^ v;
      end
      2, 3, 4, 5, 12, 15, 16, 17: begin
        int x;
        x = ai;
        if (o == 12) begin x = 0; y = ai; end
        cin = (o inside {3, 5, 16}) ? int'(c) : 0;
        d = x - y - cin; r = d & 255; w = !(o inside {15, 16, 17});
        c = d < 0; h = ((x & 15) - (y & 15) - cin) < 0;
        sv = sgn(x) - sgn(y) - cin; v = (sv > 127) || (sv < -128);
        z = (o inside {3, 5, 16}) ? ((r == 0) && z) : (r == 0);
        n = r[7]; s = n ^ v;
      end
      6, 7, 8, 9, 10, 11: begin
        case (o)
          6, 7:    r = ai & y;
          8, 9:    r = ai | y;
          10:      r = ai ^ y;
          default: begin r = 255 - ai; c = 1; end
        endcase
        w = 1; v = 0; z = (r == 0); n = r[7]; s = n;
      end
      13, 14: begin
        r = (o == 13) ? ((ai + 1) & 255) : ((ai + 255) & 255);
        w = 1; v = (o == 13) ? (ai == 127) : (ai == 128);
        z = (r == 0); n = r[7]; s = n ^ v;
      end
      18, 20: begin
        r = ((ai << 1) | ((o == 20) ? int'(c) : 0)) & 255;
        w = 1; c = ai[7]; h = ai[3];
        z = (r == 0); n = r[7]; v = n ^ c; s = n ^ v;
      end
      19, 21, 22: begin
        r = ai >> 1;
        if (o == 21) r = r | (int'(c) << 7);
        if (o == 22) r = r | (ai & 128);
        w = 1; c = ai[0];
        z = (r == 0); n = r[7]; v = n ^ c; s = n ^ v;
      end
      23: begin
        r = ((ai & 15) << 4) | (ai >> 4); w = 1;
      end
      default: ;
    endcase
    nf = {h, s, v, n, z, c};
  endtask

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, expv);
    end
  endtask

  task automatic step(input int o, input int ai, input int bi, input int ii,
                      input bit e);
    int r; bit w; logic [5:0] nf;
    @(negedge clk);
    op = 5'(o); a = 8'(ai); b = 8'(bi); imm = 8'(ii); en = e;
    model(o, ai, bi, ii, exp_fl, r, w, nf);
    #1;
    check(wr == w, req_of(o), "wr_o", int'(wr), int'(w));
    if (w) check(res == 8'(r), req_of(o), "res_o", int'(res), r);
    @(posedge clk);
    #1;
    en = 1'b0;
    if (e) exp_fl = nf;
    check(flags == exp_fl, e ? req_of(o) : "R12", "flags_o",
          int'(flags), int'(exp_fl));
  endtask

  initial begin
    #20000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(flags == 6'd0, "R1", "flags_o after reset", int'(flags), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(flags == 6'd0, "R1", "flags_o after release", int'(flags), 0);

    // R2 corners
    step(0, 8'h7F, 8'h01, 0, 1);
    step(0, 8'hFF, 8'h01, 0, 1);
    step(1, 8'h10, 8'h20, 0, 1);
    // R3 corners
    step(2, 8'h80, 8'h01, 0, 1);
    step(4, 8'h00, 0, 8'h01, 1);
    step(12, 8'h80, 0, 0, 1);
    step(12, 8'h00, 0, 0, 1);
    // R4/R5 chained compare: equal then equal keeps Z
    step(15, 8'h34, 8'h34, 0, 1);
    step(16, 8'h12, 8'h12, 0, 1);
    // differing low byte then equal high byte: Z stays clear
    step(17, 8'h35, 0, 8'h34, 1);
    step(16, 8'h12, 8'h12, 0, 1);
    step(5, 8'h12, 0, 8'h12, 1);
    // R9 sets H, then R6/R7/R10 must keep it
    step(18, 8'h88, 0, 0, 1);
    step(6, 8'hF0, 8'h0F, 0, 1);
    step(11, 8'h00, 0, 0, 1);
    step(22, 8'h81, 0, 0, 1);
    step(21, 8'h02, 0, 0, 1);
    step(20, 8'h40, 0, 0, 1);
    // R8 overflow edges
    step(13, 8'h7F, 0, 0, 1);
    step(14, 8'h80, 0, 0, 1);
    // R11 and R13
    step(23, 8'h3C, 0, 0, 1);
    step(25, 8'hAA, 8'h55, 8'h11, 1);
    step(31, 8'h00, 8'h00, 8'h00, 1);
    // R12 strobe low holds flags
    step(0, 8'hFF, 8'hFF, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      int o;
      o = ($urandom_range(0, 19) == 0) ? int'($urandom_range(24, 31))
                                       : int'($urandom_range(0, 23));
      step(o, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
           int'($urandom_range(0, 255)), $urandom_range(0, 7) != 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule